// File: doc/BRIEF.md
# Matched-Filter Spectrum Multiplier

This block sits between the forward transform and the inverse transform of a frequency-domain pulse compressor. The forward pass streams its spectrum out one bin per clock. Each bin carries a signed 16-bit real part and a signed 16-bit imaginary part. The block multiplies every bin by the complex matched-filter coefficient stored for that bin. It emits the 16-bit complex product together with a result-memory write strobe and a write address, two clock cycles after the bin arrives.

A coefficient store is loaded through a simple write port before a frame streams through. A bin sequencer derives the coefficient address from a start-of-frame marker and the valid strobe. Each product term is formed at full width, the terms are combined at 33 bits, and the upper 16 bits are kept.

Two small helpers round out the datapath:
- An adder combines the block exponents reported by the forward and inverse block-floating-point passes.
- A widener turns 14-bit converter samples into 16-bit transform inputs.

Top module: `mfm_top`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid bin, `res_we` is 0 and `prod_re`, `prod_im` and `res_waddr` are all 0.
- R2: For a bin (ar, ai) multiplied by the coefficient (br, bi), `prod_re` is bits 32..17 of the 33-bit signed value ar*br − ai*bi. `prod_im` is bits 32..17 of ar*bi + ai*br.
- R3: No combination of operand values, including −32768 on every operand, overflows the 33-bit sums. The 33-bit sums always lie within ±2^31.
- R4: `res_we` is 1 in exactly those cycles that come two clock edges after an edge at which `spec_valid` was 1. The product and address presented with it belong to that bin.
- R5: The bin index advances by one for each valid bin. Idle cycles leave it unchanged. `res_waddr` is that bin index delayed by two cycles.
- R6: A valid bin with `spec_sof` = 1 uses bin index 0 and restarts the count, even in the middle of a frame.
- R7: The bin index is 10 bits wide and wraps from 1023 to 0.
- R8: A coefficient written through `coef_we`/`coef_waddr`/`coef_wre`/`coef_wim` at a clock edge is used for every later bin with that index.
- R9: `blk_exp` equals `fwd_exp + inv_exp` as a 6-bit unsigned sum, combinationally.
- R10: `adc_wide` equals `adc_raw` with two zero bits appended below its least significant bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_we | input | 1 | Coefficient store write enable |
| coef_waddr | input | 10 | Coefficient store write index |
| coef_wre | input | 16 | Coefficient real part to store |
| coef_wim | input | 16 | Coefficient imaginary part to store |
| spec_valid | input | 1 | Spectrum bin valid |
| spec_sof | input | 1 | Marks the first bin of a frame |
| spec_re | input | 16 | Spectrum real part, signed |
| spec_im | input | 16 | Spectrum imaginary part, signed |
| fwd_exp | input | 5 | Forward-pass block exponent |
| inv_exp | input | 5 | Inverse-pass block exponent |
| adc_raw | input | 14 | Converter sample, two's complement |
| adc_wide | output | 16 | Widened converter sample |
| prod_re | output | 16 | Product real part |
| prod_im | output | 16 | Product imaginary part |
| res_we | output | 1 | Result memory write enable |
| res_waddr | output | 10 | Result memory write address |
| blk_exp | output | 6 | Combined block exponent |

## Verification
The product, the write strobe and the write address are all due two rising edges after the edge that captured the bin. The bench snapshots the inputs at each rising edge and computes the expected product from its own copy of the coefficients. It then shifts that snapshot through a two-deep queue and compares the outputs 2 ns after the second following edge, which leaves a cycle free of idle bins unchecked never. The exponent sum and the widened sample have no register on their path. They are checked 1 ns after their inputs change, between clock edges.

// File: rtl/mfm_pkg.sv
package mfm_pkg;
  localparam int unsigned DW      = 16;
  localparam int unsigned BINS    = 1024;
  localparam int unsigned AW      = $clog2(BINS);
  localparam int unsigned EXPW    = 5;
  localparam int unsigned ADC_W   = 14;
  localparam int unsigned LAT     = 2;
  localparam int unsigned SUMW    = 2 * DW + 1;
endpackage

// File: rtl/mfm_coef_store.sv
module mfm_coef_store #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = $clog2(DEPTH),
  parameter int unsigned DW    = 16
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [DW-1:0] wre,
  input  logic signed [DW-1:0] wim,
  input  logic [AW-1:0]        raddr,
  output logic signed [DW-1:0] rre,
  output logic signed [DW-1:0] rim
);
  localparam int unsigned WW = 2 * DW;

  logic [WW-1:0] mem [DEPTH];
  logic [WW-1:0] rword;

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= {wre, wim};
    end
  end

  assign rword = mem[raddr];
  assign rre   = rword[WW-1:DW];
  assign rim   = rword[DW-1:0];
endmodule

// File: rtl/mfm_bin_seq.sv
module mfm_bin_seq #(
  parameter int unsigned AW  = 10,
  parameter int unsigned LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic [AW-1:0] rd_addr,
  output logic          s1_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);
  logic [AW-1:0] cnt_q, cnt_d;

  assign rd_addr = in_sof ? '0 : cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid) begin
      cnt_d = rd_addr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < LAT; g++) begin : g_stg
    logic          v_q;
    logic [AW-1:0] a_q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          a_q <= '0;
        end else begin
          v_q <= in_valid;
          if (in_valid) a_q <= rd_addr;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          a_q <= '0;
        end else begin
          v_q <= g_stg[g-1].v_q;
          if (g_stg[g-1].v_q) a_q <= g_stg[g-1].a_q;
        end
      end
    end
  end

  assign s1_valid = g_stg[0].v_q;
  assign wr_en    = g_stg[LAT-1].v_q;
  assign wr_addr  = g_stg[LAT-1].a_q;

  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (g_stg[0].a_q == '0)); // R6
endmodule

// File: rtl/mfm_cmul_pipe.sv
module mfm_cmul_pipe #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_s1,
  input  logic                 en_s2,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int unsigned PW   = 2 * DW;
  localparam int unsigned SUMW = PW + 1;
  localparam logic signed [SUMW-1:0] LIM_HI = {2'b01, {(PW-1){1'b0}}};
  localparam logic signed [SUMW-1:0] LIM_LO = -LIM_HI;

  logic signed [PW-1:0]   p_rr_q, p_ii_q, p_ri_q, p_ir_q;
  logic signed [PW-1:0]   p_rr_d, p_ii_d, p_ri_d, p_ir_d;
  logic signed [SUMW-1:0] s_re_d, s_im_d;
  logic signed [DW-1:0]   y_re_q, y_im_q;

  always_comb begin
    p_rr_d = a_re * b_re;
    p_ii_d = a_im * b_im;
    p_ri_d = a_re * b_im;
    p_ir_d = a_im * b_re;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rr_q <= '0;
      p_ii_q <= '0;
      p_ri_q <= '0;
      p_ir_q <= '0;
    end else if (en_s1) begin
      p_rr_q <= p_rr_d;
      p_ii_q <= p_ii_d;
      p_ri_q <= p_ri_d;
      p_ir_q <= p_ir_d;
    end
  end

  always_comb begin
    s_re_d = {p_rr_q[PW-1], p_rr_q} - {p_ii_q[PW-1], p_ii_q};
    s_im_d = {p_ri_q[PW-1], p_ri_q} + {p_ir_q[PW-1], p_ir_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_re_q <= '0;
      y_im_q <= '0;
    end else if (en_s2) begin
      y_re_q <= s_re_d[SUMW-1 -: DW];
      y_im_q <= s_im_d[SUMW-1 -: DW];
    end
  end

  assign y_re = y_re_q;
  assign y_im = y_im_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    en_s2 |-> (s_re_d <= LIM_HI && s_re_d >= LIM_LO &&
               s_im_d <= LIM_HI && s_im_d >= LIM_LO)); // R3
endmodule

// File: rtl/mfm_top.sv
module mfm_top
  import mfm_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   coef_we,
  input  logic [AW-1:0]          coef_waddr,
  input  logic signed [DW-1:0]   coef_wre,
  input  logic signed [DW-1:0]   coef_wim,
  input  logic                   spec_valid,
  input  logic                   spec_sof,
  input  logic signed [DW-1:0]   spec_re,
  input  logic signed [DW-1:0]   spec_im,
  input  logic [EXPW-1:0]        fwd_exp,
  input  logic [EXPW-1:0]        inv_exp,
  input  logic [ADC_W-1:0]       adc_raw,
  output logic [DW-1:0]          adc_wide,
  output logic signed [DW-1:0]   prod_re,
  output logic signed [DW-1:0]   prod_im,
  output logic                   res_we,
  output logic [AW-1:0]          res_waddr,
  output logic [EXPW:0]          blk_exp
);
  localparam int unsigned PAD = DW - ADC_W;

  logic rst_q1, rst_q2, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_sync_n = rst_q2;

  logic [AW-1:0]        rd_addr;
  logic                 s1_valid;
  logic signed [DW-1:0] c_re, c_im;

  mfm_bin_seq #(.AW(AW), .LAT(LAT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (spec_valid),
    .in_sof   (spec_sof),
    .rd_addr  (rd_addr),
    .s1_valid (s1_valid),
    .wr_en    (res_we),
    .wr_addr  (res_waddr)
  );

  mfm_coef_store #(.DEPTH(BINS), .AW(AW), .DW(DW)) u_coef (
    .clk   (clk),
    .we    (coef_we),
    .waddr (coef_waddr),
    .wre   (coef_wre),
    .wim   (coef_wim),
    .raddr (rd_addr),
    .rre   (c_re),
    .rim   (c_im)
  );

  mfm_cmul_pipe #(.DW(DW)) u_mul (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en_s1 (spec_valid),
    .en_s2 (s1_valid),
    .a_re  (spec_re),
    .a_im  (spec_im),
    .b_re  (c_re),
    .b_im  (c_im),
    .y_re  (prod_re),
    .y_im  (prod_im)
  );

  assign blk_exp  = {1'b0, fwd_exp} + {1'b0, inv_exp};
  assign adc_wide = {adc_raw, {PAD{1'b0}}};

  AST_WE_LAG: assert property (@(posedge clk) disable iff (!rst_sync_n)
    spec_valid |-> ##2 res_we); // R4
  AST_WE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !spec_valid |-> ##2 !res_we); // R4
  AST_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (spec_valid && spec_sof) |-> ##2 (res_waddr == '0)); // R6
  AST_EXP_MONO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blk_exp >= {1'b0, fwd_exp}) && (blk_exp >= {1'b0, inv_exp})); // R9
endmodule

// File: tb/mfm_top_tb_top.sv
module mfm_top_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n;
  logic               coef_we;
  logic [9:0]         coef_waddr;
  logic signed [15:0] coef_wre, coef_wim;
  logic               spec_valid, spec_sof;
  logic signed [15:0] spec_re, spec_im;
  logic [4:0]         fwd_exp, inv_exp;
  logic [13:0]        adc_raw;
  logic [15:0]        adc_wide;
  logic signed [15:0] prod_re, prod_im;
  logic               res_we;
  logic [9:0]         res_waddr;
  logic [5:0]         blk_exp;

  mfm_top dut_i (.*);

  int n_cmp = 0;
  int n_bad = 0;
  logic signed [15:0] mref_re [1024];
  logic signed [15:0] mref_im [1024];
  logic mon_on = 1'b0;
  string data_req = "R2";
  string addr_req = "R5";

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // bench-side two-stage model
  logic [9:0]         bcnt = '0;
  logic               s1_v = 1'b0, s2_v = 1'b0;
  logic [15:0]        s1_re, s1_im, s2_re, s2_im;
  logic [9:0]         s1_a, s2_a;

  always @(posedge clk) begin
    if (mon_on) begin
      logic signed [63:0] pr, pi;
      logic [9:0] a;
      s2_v = s1_v; s2_re = s1_re; s2_im = s1_im; s2_a = s1_a;
      s1_v = spec_valid;
      if (spec_valid) begin
        a  = spec_sof ? 10'd0 : bcnt;
        bcnt = a + 10'd1;
        pr = 64'(spec_re) * 64'(mref_re[a]) - 64'(spec_im) * 64'(mref_im[a]);
        pi = 64'(spec_re) * 64'(mref_im[a]) + 64'(spec_im) * 64'(mref_re[a]);
        s1_re = pr[32:17];
        s1_im = pi[32:17];
        s1_a  = a;
      end
      #2;
      chk("R4", "res_we", res_we, s2_v);
      if (s2_v) begin
        chk(data_req, "prod_re", prod_re, $signed(s2_re));
        chk(data_req, "prod_im", prod_im, $signed(s2_im));
        chk(addr_req, "res_waddr", res_waddr, s2_a);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      spec_valid = 1'b0; spec_sof = 1'b0;
    end
  endtask

  task automatic send(input logic sof, input logic signed [15:0] re, input logic signed [15:0] im);
    @(negedge clk);
    spec_valid = 1'b1; spec_sof = sof; spec_re = re; spec_im = im;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "res_we in reset", res_we, 0);
    chk("R1", "prod_re in reset", prod_re, 0);
    chk("R1", "prod_im in reset", prod_im, 0);
    chk("R1", "res_waddr in reset", res_waddr, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    chk("R1", "res_we after release", res_we, 0);
    chk("R1", "prod_re after release", prod_re, 0);
    chk("R1", "res_waddr after release", res_waddr, 0);
  endtask

  // R8: load the coefficient store through its write port
  task automatic t_load;
    for (int i = 0; i < 1024; i++) begin
      @(negedge clk);
      coef_we = 1'b1; coef_waddr = 10'(i);
      coef_wre = 16'(i * 73 - 20000); coef_wim = 16'(15000 - i * 41);
      if (i == 0) begin coef_wre = -16'sd32768; coef_wim = -16'sd32768; end
      if (i == 1) begin coef_wre = 16'sd32767;  coef_wim = 16'sd0; end
      if (i == 2) begin coef_wre = -16'sd32768; coef_wim = 16'sd32767; end
      mref_re[i] = coef_wre; mref_im[i] = coef_wim;
    end
    @(negedge clk); coef_we = 1'b0;
    mon_on = 1'b1;
  endtask

  task automatic t_frame;
    data_req = "R2"; addr_req = "R5";
    send(1'b1, 16'sd1000, -16'sd2000);
    for (int i = 1; i < 24; i++) send(1'b0, 16'(i * 1311 - 9000), 16'(7000 - i * 977));
    idle(4);
  endtask

  task automatic t_extreme;
    data_req = "R3"; addr_req = "R6";
    send(1'b1, -16'sd32768, -16'sd32768);
    send(1'b0, -16'sd32768, 16'sd32767);
    send(1'b0, -16'sd32768, -16'sd32768);
    send(1'b0, 16'sd32767, 16'sd32767);
    idle(4);
  endtask

  task automatic t_bubbles;
    data_req = "R2"; addr_req = "R5";
    send(1'b1, 16'sd300, 16'sd400);
    idle(2);
    send(1'b0, -16'sd500, 16'sd600);
    idle(1);
    send(1'b0, 16'sd700, -16'sd800);
    send(1'b0, 16'sd12345, 16'sd23456);
    idle(4);
  endtask

  task automatic t_restart;
    data_req = "R2"; addr_req = "R6";
    send(1'b1, 16'sd11, 16'sd22);
    for (int i = 0; i < 6; i++) send(1'b0, 16'(i * 5000), 16'(-i * 3000));
    send(1'b1, 16'sd4096, -16'sd4096);
    send(1'b0, 16'sd8192, 16'sd1);
    idle(4);
  endtask

  task automatic t_reload;
    data_req = "R8"; addr_req = "R5";
    @(negedge clk);
    coef_we = 1'b1; coef_waddr = 10'd3; coef_wre = 16'sd20000; coef_wim = -16'sd12000;
    mref_re[3] = 16'sd20000; mref_im[3] = -16'sd12000;
    @(negedge clk); coef_we = 1'b0;
    send(1'b1, 16'sd1, 16'sd2);
    for (int i = 1; i < 5; i++) send(1'b0, 16'sd30000, -16'sd25000);
    idle(4);
  endtask

  task automatic t_wrap;
    data_req = "R2"; addr_req = "R7";
    send(1'b1, 16'sd100, 16'sd200);
    for (int i = 1; i < 1030; i++) send(1'b0, 16'(i * 31), 16'(-i * 17));
    idle(4);
  endtask

  task automatic t_exp;
    @(negedge clk); fwd_exp = 5'd31; inv_exp = 5'd31; #1;
    chk("R9", "blk_exp 31+31", blk_exp, 62);
    @(negedge clk); fwd_exp = 5'd0; inv_exp = 5'd0; #1;
    chk("R9", "blk_exp 0+0", blk_exp, 0);
    @(negedge clk); fwd_exp = 5'd17; inv_exp = 5'd5; #1;
    chk("R9", "blk_exp 17+5", blk_exp, 22);
  endtask

  task automatic t_widen;
    @(negedge clk); adc_raw = 14'h2001; #1;
    chk("R10", "adc_wide", adc_wide, 16'h8004);
    @(negedge clk); adc_raw = 14'h1FFF; #1;
    chk("R10", "adc_wide", adc_wide, 16'h7FFC);
    @(negedge clk); adc_raw = 14'h3FFF; #1;
    chk("R10", "adc_wide", adc_wide, 16'hFFFC);
  endtask

  initial begin
    rst_n = 1'b0; coef_we = 1'b0; coef_waddr = '0; coef_wre = '0; coef_wim = '0;
    spec_valid = 1'b0; spec_sof = 1'b0; spec_re = '0; spec_im = '0;
    fwd_exp = '0; inv_exp = '0; adc_raw = '0;
    t_reset();
    t_load();
    t_frame();
    t_extreme();
    t_bubbles();
    t_restart();
    t_reload();
    t_wrap();
    t_exp();
    t_widen();
    mon_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule